// File: doc/BRIEF.md
# PWM Pair Software Override Stage

This block is the last stage between a PWM generator and the output pins for one complementary channel pair. It takes the generator's even and odd duty signals and lets software override either channel, inserts deadtime when the pair runs complementary, and applies a per-pin polarity before the pins.

In independent mode each channel is chosen on its own: the generator signal, or the software bit when that channel's override enable is set. In complementary mode one source feeds a deadtime inserter. That source is the generator's even signal, or the even software bit when the even override enable is set. The inserter drives both outputs so they are never active together. It leaves a programmable gap whenever the source changes. The odd software bit does not drive the odd pin. Under complementary override it chooses between letting the bottom output act as the complement and forcing it inactive. Polarity is applied last, so negative polarity turns the inactive level into a high pin.

Every path from an input to a pin goes through three register stages, so a change in control shows up at the pins three clocks later.

Top module: `pwm_pair_ovr_stage`

## Requirements
- R1: In independent mode with a channel's override enable set (sw_en_i bit 0 = top/even, bit 1 = bottom/odd), that channel's active state equals its software bit (sw_val_i, same bit order): 1 = active, 0 = inactive.
- R2: In independent mode with a channel's override enable clear, the channel's active state follows its generator input (gen_even_i for top, gen_odd_i for bottom).
- R3: In complementary mode (cmpl_mode_i = 1), only sw_en_i[0] selects software control for the pair; sw_en_i[1] has no effect on either pin.
- R4: In complementary mode, the top output is active when the source is 1 and the bottom output is active when the source is 0; the two are never active in the same cycle.
- R5: In complementary mode, after the source changes, both outputs are held inactive for exactly dead_cnt_i cycles (the value sampled with the change) before the newly active output is asserted; with a count of 0 the switch happens with no gap.
- R6: If the source changes again before the deadtime count has expired, the count restarts from the sampled dead_cnt_i, and neither output is asserted until a full interval passes with a stable source.
- R7: In complementary mode with sw_en_i[0] set, sw_val_i[1] = 1 lets the bottom output act as the complement of the top, and sw_val_i[1] = 0 holds the bottom output inactive.
- R8: Each pin equals its active state XOR its polarity select (top_neg_i for pin_top_o, bot_neg_i for pin_bot_o). This holds under software override as well.
- R9: With dead_cnt_i = 0, an input change sampled at clock edge k reaches the pins at edge k+2, so three clocks after it is applied.
- R10: While rst_n is low, each pin sits at its inactive level (equal to its live polarity select), and the pipeline and deadtime state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_even_i | input | 1 | Generator duty signal, even (top) channel |
| gen_odd_i | input | 1 | Generator duty signal, odd (bottom) channel |
| cmpl_mode_i | input | 1 | 1 = complementary pair, 0 = independent channels |
| sw_en_i | input | 2 | Software override enables, bit 0 top, bit 1 bottom |
| sw_val_i | input | 2 | Software output values, bit 0 top, bit 1 bottom |
| dead_cnt_i | input | DT_W | Deadtime length in clock cycles |
| top_neg_i | input | 1 | 1 = negative polarity on the top pin |
| bot_neg_i | input | 1 | 1 = negative polarity on the bottom pin |
| pin_top_o | output | 1 | Top (even) pin level |
| pin_bot_o | output | 1 | Bottom (odd) pin level |

## Verification
The latency property takes for granted that reset is held low from time zero. It checks only once three cycles have passed since reset, because the inputs sampled during reset never enter the pipeline. The deadtime properties assume the count input can change at any time and read it only in the cycle it is sampled. In complementary mode the random stimulus writes the two override enables as a pair, as the block's usage expects. It changes the deadtime count only now and then, keeps it small so that the hold windows finish inside the run, and toggles the sources often enough that deadtime restarts occur.

// File: rtl/pwm_ovr_pkg.sv
// Package: shared types for the PWM pair override stage.
// Assumes channel index 0 is the top (even) channel and 1 the bottom (odd).
package pwm_ovr_pkg;

    typedef enum logic {
        MODE_INDEP = 1'b0,
        MODE_CMPL  = 1'b1
    } pair_mode_e;

    localparam int CH_TOP   = 0;
    localparam int CH_BOT   = 1;
    localparam int N_CH     = 2;

    typedef struct packed {
        logic             even_gen;
        logic             odd_gen;
        pair_mode_e       mode;
        logic [N_CH-1:0]  sw_en;
        logic [N_CH-1:0]  sw_val;
    } ctl_s;

endpackage

// File: rtl/pwm_ovr_in_reg.sv
// Module: first pipeline stage. Registers the generator signals, mode,
// override controls and deadtime count. Polarity selects are registered
// without reset so the pins' inactive level is known straight after reset.
// Assumes all inputs are synchronous to clk.
module pwm_ovr_in_reg
    import pwm_ovr_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ctl_s                 ctl_i,
    input  logic [DT_W-1:0]      dead_i,
    input  logic [N_CH-1:0]      neg_i,
    output ctl_s                 ctl_q,
    output logic [DT_W-1:0]      dead_q,
    output logic [N_CH-1:0]      neg_q
);

    // Capture control and deadtime; cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            dead_q <= '0;
        end else begin
            ctl_q  <= ctl_i;
            dead_q <= dead_i;
        end
    end

    // Capture polarity every cycle, reset or not.
    always_ff @(posedge clk) begin
        neg_q <= neg_i;
    end

endmodule

// File: rtl/pwm_ovr_src_sel.sv
// Module: combinational source selection. For each channel it picks the
// generator or software bit (independent path) and forms the single
// complementary source plus the bottom-permit flag.
// Assumes only the even enable governs complementary override.
module pwm_ovr_src_sel
    import pwm_ovr_pkg::*;
(
    input  ctl_s              ctl_i,
    output logic [N_CH-1:0]   ind_act_o,
    output logic              cmpl_src_o,
    output logic              bot_permit_o
);

    logic [N_CH-1:0] gen_vec;

    // Gather generator signals in channel order.
    always_comb begin
        gen_vec[CH_TOP] = ctl_i.even_gen;
        gen_vec[CH_BOT] = ctl_i.odd_gen;
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ind
        // Per-channel independent choice between generator and software.
        always_comb begin
            ind_act_o[ch] = ctl_i.sw_en[ch] ? ctl_i.sw_val[ch] : gen_vec[ch];
        end
    end

    // Complementary source and odd gating, both keyed on the even enable.
    always_comb begin
        cmpl_src_o   = ctl_i.sw_en[CH_TOP] ? ctl_i.sw_val[CH_TOP] : ctl_i.even_gen;
        bot_permit_o = ctl_i.sw_en[CH_TOP] ? ctl_i.sw_val[CH_BOT] : 1'b1;
    end

endmodule

// File: rtl/pwm_ovr_deadtime.sv
// Module: second pipeline stage. Tracks the complementary source, reloads a
// down-counter on each source change, and registers the active state of
// both channels. In independent mode the selected channel states pass.
// Assumes dead_i is sampled only in the cycle a change is seen.
module pwm_ovr_deadtime
    import pwm_ovr_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  pair_mode_e           mode_i,
    input  logic                 src_i,
    input  logic                 bot_permit_i,
    input  logic [N_CH-1:0]      ind_act_i,
    input  logic [DT_W-1:0]      dead_i,
    input  logic [N_CH-1:0]      neg_i,
    output logic [N_CH-1:0]      act_q,
    output logic [N_CH-1:0]      neg_q
);

    localparam logic [DT_W-1:0] CNT_ZERO = '0;
    localparam logic [DT_W-1:0] CNT_ONE  = DT_W'(1);

    logic              prev_q;
    logic [DT_W-1:0]   cnt_q;
    pair_mode_e        mode_q;
    logic [DT_W-1:0]   cnt_d;
    logic              src_chg;
    logic              settled;
    logic [N_CH-1:0]   act_d;

    // Next deadtime count: reload on change, else count down to zero.
    always_comb begin
        src_chg = (src_i != prev_q);
        if (src_chg) begin
            cnt_d = dead_i;
        end else if (cnt_q != CNT_ZERO) begin
            cnt_d = cnt_q - CNT_ONE;
        end else begin
            cnt_d = CNT_ZERO;
        end
        settled = (cnt_d == CNT_ZERO);
    end

    // Active state per mode: exclusive pair or independent pass-through.
    always_comb begin
        if (mode_i == MODE_CMPL) begin
            act_d[CH_TOP] = src_i && settled;
            act_d[CH_BOT] = !src_i && settled && bot_permit_i;
        end else begin
            act_d = ind_act_i;
        end
    end

    // Deadtime state and stage-two output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cnt_q  <= CNT_ZERO;
            act_q  <= '0;
            mode_q <= MODE_INDEP;
        end else begin
            prev_q <= src_i;
            cnt_q  <= cnt_d;
            act_q  <= act_d;
            mode_q <= mode_i;
        end
    end

    // Polarity follows the data one more stage.
    always_ff @(posedge clk) begin
        neg_q <= neg_i;
    end

    // R4: a complementary pair never has both outputs active.
    p_pair_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CMPL) |-> !(act_q[CH_TOP] && act_q[CH_BOT]));

    // R5: while the deadtime count runs, both outputs stay inactive.
    p_dt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CMPL && cnt_q != CNT_ZERO) |-> (act_q == 2'b00));

    // R6: a source change reloads the count from the sampled deadtime.
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != prev_q) |=> (cnt_q == $past(dead_i)));

    // R6: with a stable source the count steps down by one.
    p_cnt_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == prev_q && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

endmodule

// File: rtl/pwm_ovr_pin_drv.sv
// Module: third pipeline stage. Registers each pin as its active state
// XOR polarity. In reset each pin loads its live polarity select, which is
// that pin's inactive level.
// Assumes neg_live_i is the undelayed polarity select.
module pwm_ovr_pin_drv
    import pwm_ovr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CH-1:0]    act_i,
    input  logic [N_CH-1:0]    neg_i,
    input  logic [N_CH-1:0]    neg_live_i,
    output logic [N_CH-1:0]    pin_q
);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_pin
        // Per-channel pin register with polarity applied last.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pin_q[ch] <= neg_live_i[ch];
            end else begin
                pin_q[ch] <= act_i[ch] ^ neg_i[ch];
            end
        end
    end

endmodule

// File: rtl/pwm_pair_ovr_stage.sv
// Module: top of the PWM pair override stage. Three register stages link
// the inputs to the pins: input capture, deadtime/selection, pin drive.
// Assumes synchronous inputs and a synchronous active-low reset.
module pwm_pair_ovr_stage
    import pwm_ovr_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_even_i,
    input  logic              gen_odd_i,
    input  logic              cmpl_mode_i,
    input  logic [1:0]        sw_en_i,
    input  logic [1:0]        sw_val_i,
    input  logic [DT_W-1:0]   dead_cnt_i,
    input  logic              top_neg_i,
    input  logic              bot_neg_i,
    output logic              pin_top_o,
    output logic              pin_bot_o
);

    localparam int WARM_MAX = 3;

    ctl_s              ctl_in;
    ctl_s              ctl_s1;
    logic [DT_W-1:0]   dead_s1;
    logic [N_CH-1:0]   neg_live;
    logic [N_CH-1:0]   neg_s1;
    logic [N_CH-1:0]   neg_s2;
    logic [N_CH-1:0]   ind_act;
    logic              cmpl_src;
    logic              bot_permit;
    logic [N_CH-1:0]   act_s2;
    logic [N_CH-1:0]   pin_vec;
    logic [1:0]        warm_q;

    // Pack the port-level controls into the stage record.
    always_comb begin
        ctl_in.even_gen     = gen_even_i;
        ctl_in.odd_gen      = gen_odd_i;
        ctl_in.mode         = pair_mode_e'(cmpl_mode_i);
        ctl_in.sw_en        = sw_en_i;
        ctl_in.sw_val       = sw_val_i;
        neg_live[CH_TOP]    = top_neg_i;
        neg_live[CH_BOT]    = bot_neg_i;
    end

    pwm_ovr_in_reg #(.DT_W(DT_W)) in_reg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_i  (ctl_in),
        .dead_i (dead_cnt_i),
        .neg_i  (neg_live),
        .ctl_q  (ctl_s1),
        .dead_q (dead_s1),
        .neg_q  (neg_s1)
    );

    pwm_ovr_src_sel src_sel_i (
        .ctl_i        (ctl_s1),
        .ind_act_o    (ind_act),
        .cmpl_src_o   (cmpl_src),
        .bot_permit_o (bot_permit)
    );

    pwm_ovr_deadtime #(.DT_W(DT_W)) deadtime_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (ctl_s1.mode),
        .src_i        (cmpl_src),
        .bot_permit_i (bot_permit),
        .ind_act_i    (ind_act),
        .dead_i       (dead_s1),
        .neg_i        (neg_s1),
        .act_q        (act_s2),
        .neg_q        (neg_s2)
    );

    pwm_ovr_pin_drv pin_drv_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (act_s2),
        .neg_i      (neg_s2),
        .neg_live_i (neg_live),
        .pin_q      (pin_vec)
    );

    // Drive the pins from the pin-stage vector.
    always_comb begin
        pin_top_o = pin_vec[CH_TOP];
        pin_bot_o = pin_vec[CH_BOT];
    end

    // Cycles since reset, saturating, used to qualify latency checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'(WARM_MAX)) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R1: independent override makes the top channel follow its software bit.
    p_ind_override_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_s1.mode == MODE_INDEP && ctl_s1.sw_en[CH_TOP])
        |=> (act_s2[CH_TOP] == $past(ctl_s1.sw_val[CH_TOP])));

    // R7: complementary override with the odd bit clear keeps bottom inactive.
    p_odd_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_s1.mode == MODE_CMPL && ctl_s1.sw_en[CH_TOP] && !ctl_s1.sw_val[CH_BOT])
        |=> !act_s2[CH_BOT]);

    // R9: independent software value reaches the top pin three clocks later.
    p_ind_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'(WARM_MAX) && $past(!cmpl_mode_i && sw_en_i[0], 3))
        |-> (pin_top_o == ($past(sw_val_i[0], 3) ^ $past(top_neg_i, 3))));

endmodule

// File: tb/pwm_pair_ovr_stage_tb.sv
// Bench: directed corner cases then seeded random stimulus checked against
// a cycle model written from the requirements.
module pwm_pair_ovr_stage_tb_top;

    localparam int DT_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            gen_even_i = 1'b0;
    logic            gen_odd_i = 1'b0;
    logic            cmpl_mode_i = 1'b0;
    logic [1:0]      sw_en_i = 2'b00;
    logic [1:0]      sw_val_i = 2'b00;
    logic [DT_W-1:0] dead_cnt_i = '0;
    logic            top_neg_i = 1'b0;
    logic            bot_neg_i = 1'b0;
    logic            pin_top_o;
    logic            pin_bot_o;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pwm_pair_ovr_stage #(.DT_W(DT_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .gen_even_i  (gen_even_i),
        .gen_odd_i   (gen_odd_i),
        .cmpl_mode_i (cmpl_mode_i),
        .sw_en_i     (sw_en_i),
        .sw_val_i    (sw_val_i),
        .dead_cnt_i  (dead_cnt_i),
        .top_neg_i   (top_neg_i),
        .bot_neg_i   (bot_neg_i),
        .pin_top_o   (pin_top_o),
        .pin_bot_o   (pin_bot_o)
    );

    // Reference model state.
    logic            m_even, m_odd, m_cmpl, m_prev, m_mode2;
    logic [1:0]      m_en, m_val, m_act, m_neg1, m_neg2, m_pin;
    logic [DT_W-1:0] m_dead, m_cnt;

    function automatic logic [1:0] pins();
        return {pin_bot_o, pin_top_o};
    endfunction

    function automatic logic [DT_W-1:0] next_count(logic chg, logic [DT_W-1:0] d,
                                                   logic [DT_W-1:0] c);
        if (chg) return d;
        if (c != '0) return c - 1'b1;
        return '0;
    endfunction

    // Cycle model of the three stages.
    always @(posedge clk) begin
        logic src, sett;
        logic [DT_W-1:0] nc;
        logic [1:0] a;
        m_neg1 <= {bot_neg_i, top_neg_i};
        m_neg2 <= m_neg1;
        if (!rst_n) begin
            m_even <= 0; m_odd <= 0; m_cmpl <= 0; m_en <= 0; m_val <= 0; m_dead <= 0;
            m_prev <= 0; m_cnt <= 0; m_act <= 0; m_mode2 <= 0;
            m_pin  <= {bot_neg_i, top_neg_i};
        end else begin
            m_even <= gen_even_i; m_odd <= gen_odd_i; m_cmpl <= cmpl_mode_i;
            m_en <= sw_en_i; m_val <= sw_val_i; m_dead <= dead_cnt_i;
            src  = m_en[0] ? m_val[0] : m_even;
            nc   = next_count(src != m_prev, m_dead, m_cnt);
            sett = (nc == '0);
            if (m_cmpl) begin
                a[0] = src & sett;
                a[1] = ~src & sett & (m_en[0] ? m_val[1] : 1'b1);
            end else begin
                a[0] = m_en[0] ? m_val[0] : m_even;
                a[1] = m_en[1] ? m_val[1] : m_odd;
            end
            m_prev  <= src;
            m_cnt   <= nc;
            m_act   <= a;
            m_mode2 <= m_cmpl;
            m_pin   <= m_act ^ m_neg2;
        end
    end

    task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: pins {bot,top} = %b, expected %b", req, got, exp);
        end
    endtask

    // Model comparison on every falling edge while enabled.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk(m_mode2 ? "R5" : "R2", pins(), m_pin);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_in(logic cm, logic ge, logic go, logic [1:0] en,
                          logic [1:0] val, int d);
        cmpl_mode_i = cm; gen_even_i = ge; gen_odd_i = go;
        sw_en_i = en; sw_val_i = val; dead_cnt_i = DT_W'(d);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R10: in reset each pin shows its polarity select.
        top_neg_i = 1'b1; bot_neg_i = 1'b0;
        step(4);
        chk("R10", pins(), 2'b01);
        top_neg_i = 1'b0; bot_neg_i = 1'b1;
        step(2);
        chk("R10", pins(), 2'b10);
        bot_neg_i = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        chk("R10", pins(), 2'b00);
        model_on = 1'b1;
        step(4);

        // R2 and R9: independent generator path, three-clock latency.
        set_in(0, 1, 1, 2'b00, 2'b00, 0);
        step(2);
        chk("R9", pins(), 2'b00);
        step(1);
        chk("R2", pins(), 2'b11);

        // R1: independent override, top on, bottom off while generators high.
        set_in(0, 1, 1, 2'b11, 2'b01, 0);
        step(3);
        chk("R1", pins(), 2'b01);

        // R8: negative polarity on both pins under override.
        top_neg_i = 1'b1; bot_neg_i = 1'b1;
        step(3);
        chk("R8", pins(), 2'b10);
        top_neg_i = 1'b0; bot_neg_i = 1'b0;
        step(3);

        // R4: complementary, generator low gives bottom active.
        set_in(1, 0, 0, 2'b00, 2'b00, 3);
        step(10);
        chk("R4", pins(), 2'b10);

        // R5: rising source holds both inactive for 3 cycles.
        gen_even_i = 1'b1;
        step(3);
        chk("R5", pins(), 2'b00);
        step(2);
        chk("R5", pins(), 2'b00);
        step(1);
        chk("R5", pins(), 2'b01);

        // R6: short low pulse restarts the deadtime count.
        step(4);
        gen_even_i = 1'b0;
        step(2);
        gen_even_i = 1'b1;
        step(2);
        chk("R6", pins(), 2'b00);
        step(3);
        chk("R6", pins(), 2'b00);
        step(1);
        chk("R6", pins(), 2'b01);

        // R7: complementary override, odd bit gates the bottom output.
        set_in(1, 0, 0, 2'b01, 2'b11, 0);
        step(4);
        chk("R7", pins(), 2'b01);
        sw_val_i = 2'b00;
        step(4);
        chk("R7", pins(), 2'b00);
        sw_val_i = 2'b10;
        step(4);
        chk("R7", pins(), 2'b10);

        // R3: odd enable alone does not override in complementary mode.
        set_in(1, 1, 0, 2'b10, 2'b00, 0);
        step(4);
        chk("R3", pins(), 2'b01);
        sw_en_i = 2'b01;
        step(4);
        chk("R3", pins(), 2'b00);

        // R8: polarity under complementary override.
        set_in(1, 1, 1, 2'b11, 2'b10, 0);
        top_neg_i = 1'b1; bot_neg_i = 1'b1;
        step(4);
        chk("R8", pins(), 2'b01);

        // Random phase, seeded, compared against the model every cycle.
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] e;
            if ($urandom_range(0, 99) < 3) cmpl_mode_i = $urandom_range(0, 1);
            gen_even_i = ($urandom_range(0, 3) == 0) ? ~gen_even_i : gen_even_i;
            gen_odd_i  = $urandom_range(0, 1);
            if ($urandom_range(0, 99) < 5) begin
                e = 2'($urandom_range(0, 3));
                sw_en_i = cmpl_mode_i ? {e[0], e[0]} : e;
            end
            if ($urandom_range(0, 99) < 10) sw_val_i = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 99) < 2) dead_cnt_i = DT_W'($urandom_range(0, 5));
            if ($urandom_range(0, 99) < 2) top_neg_i = $urandom_range(0, 1);
            if ($urandom_range(0, 99) < 2) bot_neg_i = $urandom_range(0, 1);
            step(1);
        end
        model_on = 1'b0;
        finish_run();
    end

endmodule